// File: doc/BRIEF.md
# Fail-First Vector Loop Controller

This block sequences the element operations of one vector instruction. After a start pulse it walks the element indices from 0 upward to the vector length, hands each active index to an external datapath, and reads back a per-element response: a 4-bit condition field and an exception flag. Elements whose predicate bit is clear are skipped in the same cycle and are never tested. For each element it decides whether the result and the condition field are written, and whether the loop carries on.

There are two fail-first flavours. In load/store mode a fault on the very first element (index 0) is reported as a real exception. A fault on any later element instead ends the loop quietly and shortens the vector length to that element's index, so the length never drops to zero. In condition mode one selected bit of each condition field is compared with an expected value. The first mismatch shortens the length to that element's index, which may be zero. Nothing else ever shortens it. A sub-mode turns every element into a compare: the result is never written and the equal bit is always the one tested. The loop closes with a one-cycle done pulse that carries the final length.

Top module: `ff_loop_ctrl`

## Requirements
- R1: In reset and on the cycle after it, `busy`, `done`, `issue_valid` and `exc_req` are 0 and `vl_out` is 0.
- R2: Element indices are issued strictly in ascending order starting from 0. An index whose `pred_mask` bit is 0 is never placed on `issue_idx` with `issue_valid` high.
- R3: In load/store mode (`ff_mode`=0), an element that responds with `rsp_exc`=0 asserts `wr_result` and not `wr_cond`. If no element faults, the loop ends with `vl_out` equal to `vl_in` and `exc_req`=0.
- R4: In load/store mode, a fault on element k with k>0 ends the loop with `vl_out`=k and `exc_req`=0. Element k and all later elements write nothing, and no later index is issued.
- R5: In load/store mode, a fault on index 0 ends the loop with `exc_req`=1 in the done cycle and `vl_out` equal to `vl_in`. Nothing is written for that element.
- R6: In condition mode (`ff_mode`=1), the tested bit is `rsp_cond[test_sel]`, where bit 0=less-than, 1=greater-than, 2=equal and 3=summary-overflow. An element passes when that bit equals `test_expect`. A passing element asserts both `wr_result` and `wr_cond`. `rsp_exc` has no effect in this mode.
- R7: In condition mode, the first failing element k ends the loop with `vl_out`=k, including k=0. The failing element writes neither output, and no later index is issued.
- R8: In condition mode with `rc1_mode`=1, `wr_result` is never asserted. Bit 2 (equal) is tested whatever the value of `test_sel`. A passing element asserts only `wr_cond`.
- R9: An element masked out by `pred_mask` is not tested, so its condition bits or fault flag can never shorten the length.
- R10: `done` is high for exactly one cycle per run. A run with no failure reports `vl_out` equal to `vl_in`.
- R11: While `issue_valid` is high and `rsp_valid` is low, `issue_idx` holds its value and nothing is written.
- R12: When `vl_in`=0 or no element is active, the loop ends without issuing and reports `vl_out` equal to `vl_in`.
- R13: A `start` pulse while `busy` is high is ignored. The running loop keeps its captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop; configuration sampled with it |
| ff_mode | input | 1 | 0 = load/store fail-first, 1 = condition fail-first |
| rc1_mode | input | 1 | Compare-only sub-mode of condition mode |
| test_sel | input | 2 | Condition bit under test (0 lt, 1 gt, 2 eq, 3 so) |
| test_expect | input | 1 | Value the tested bit must have to pass |
| vl_in | input | VLW | Vector length at start |
| pred_mask | input | MAXVL | Per-element predicate, 1 = active |
| issue_valid | output | 1 | An element index is presented |
| issue_idx | output | IW | Index of the presented element |
| rsp_valid | input | 1 | Datapath response for `issue_idx` is present |
| rsp_cond | input | 4 | Element condition field |
| rsp_exc | input | 1 | Element would fault |
| wr_result | output | 1 | Commit the element result |
| wr_cond | output | 1 | Commit the element condition field |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle end-of-loop pulse |
| vl_out | output | VLW | Final vector length, valid with `done` and held after |
| exc_req | output | 1 | Raise the element-0 exception, with `done` |

## Verification
A wrong running index shows at `issue_idx` on the very cycle it is presented: the index repeats, goes backwards, or lands on a masked element. A wrong configuration held in the loop shows in the response cycle of the first active element, as a wrong pair of write enables. A wrong end decision only appears at the single `done` cycle, as a wrong `vl_out` or `exc_req`. For that reason each scenario compares the final length together with the full set of written and issued indices.

// File: rtl/ff_pkg.sv
`timescale 1ns/1ps
package ff_pkg;

    localparam int COND_W = 4;

    typedef enum logic {
        MODE_LDST = 1'b0,
        MODE_COND = 1'b1
    } ff_mode_e;

    typedef enum logic [1:0] {
        CB_LT = 2'd0,
        CB_GT = 2'd1,
        CB_EQ = 2'd2,
        CB_SO = 2'd3
    } cond_bit_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } loop_state_e;

    typedef struct packed {
        logic proceed;
        logic stop_trunc;
        logic stop_raise;
        logic wr_res;
        logic wr_cond;
    } elem_verdict_t;

    function automatic logic pick_bit(input logic [COND_W-1:0] cf, input cond_bit_e sel);
        return cf[sel];
    endfunction

endpackage

// File: rtl/ff_next_active.sv
`timescale 1ns/1ps
module ff_next_active #(
    parameter int MAXVL = 16,
    parameter int IW    = $clog2(MAXVL),
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic [VLW-1:0]   from_idx,
    input  logic [VLW-1:0]   limit,
    input  logic [MAXVL-1:0] mask,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // Lowest index i with from_idx <= i < limit and mask[i] set.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MAXVL - 1; i >= 0; i--) begin
            if (VLW'(i) >= from_idx && VLW'(i) < limit && mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ff_elem_eval.sv
`timescale 1ns/1ps
module ff_elem_eval
    import ff_pkg::*;
(
    input  ff_mode_e             mode,
    input  logic                 rc1,
    input  cond_bit_e            sel,
    input  logic                 expect_val,
    input  logic                 first_elem,
    input  logic [COND_W-1:0]    cond_in,
    input  logic                 exc_in,
    output elem_verdict_t        verdict
);
    cond_bit_e tested;
    logic      pass;

    assign tested = rc1 ? CB_EQ : sel;
    assign pass   = (pick_bit(cond_in, tested) == expect_val);

    always_comb begin
        verdict = '0;
        if (mode == MODE_LDST) begin
            if (exc_in) begin
                verdict.stop_raise = first_elem;
                verdict.stop_trunc = !first_elem;
            end else begin
                verdict.proceed = 1'b1;
                verdict.wr_res  = 1'b1;
            end
        end else begin
            if (pass) begin
                verdict.proceed = 1'b1;
                verdict.wr_cond = 1'b1;
                verdict.wr_res  = !rc1;
            end else begin
                verdict.stop_trunc = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ff_seq.sv
`timescale 1ns/1ps
module ff_seq
    import ff_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int IW    = $clog2(MAXVL),
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ff_mode_e          mode_in,
    input  logic              rc1_in,
    input  cond_bit_e         sel_in,
    input  logic              exp_in,
    input  logic [VLW-1:0]    vl_in,
    input  logic [MAXVL-1:0]  mask_in,
    input  logic              na_found,
    input  logic [IW-1:0]     na_idx,
    input  logic              rsp_valid,
    input  elem_verdict_t     verdict,
    output logic [VLW-1:0]    cur,
    output ff_mode_e          cfg_mode,
    output logic              cfg_rc1,
    output cond_bit_e         cfg_sel,
    output logic              cfg_exp,
    output logic [VLW-1:0]    cfg_vl,
    output logic [MAXVL-1:0]  cfg_mask,
    output logic              issue_valid,
    output logic              busy,
    output logic              done,
    output logic [VLW-1:0]    vl_out,
    output logic              exc_req
);
    loop_state_e st_q;
    logic [VLW-1:0] vl_q;
    logic           exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cur      <= '0;
            cfg_mode <= MODE_LDST;
            cfg_rc1  <= 1'b0;
            cfg_sel  <= CB_LT;
            cfg_exp  <= 1'b0;
            cfg_vl   <= '0;
            cfg_mask <= '0;
            vl_q     <= '0;
            exc_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q     <= ST_RUN;
                        cur      <= '0;
                        cfg_mode <= mode_in;
                        cfg_rc1  <= rc1_in;
                        cfg_sel  <= sel_in;
                        cfg_exp  <= exp_in;
                        cfg_vl   <= vl_in;
                        cfg_mask <= mask_in;
                    end
                end
                ST_RUN: begin
                    if (!na_found) begin
                        st_q  <= ST_FIN;
                        vl_q  <= cfg_vl;
                        exc_q <= 1'b0;
                    end else if (rsp_valid) begin
                        if (verdict.proceed) begin
                            cur <= VLW'(na_idx) + VLW'(1);
                        end else if (verdict.stop_raise) begin
                            st_q  <= ST_FIN;
                            vl_q  <= cfg_vl;
                            exc_q <= 1'b1;
                        end else begin
                            st_q  <= ST_FIN;
                            vl_q  <= VLW'(na_idx);
                            exc_q <= 1'b0;
                        end
                    end
                end
                default: begin
                    st_q  <= ST_IDLE;
                    exc_q <= 1'b0;
                end
            endcase
        end
    end

    assign issue_valid = (st_q == ST_RUN) && na_found;
    assign busy        = (st_q != ST_IDLE);
    assign done        = (st_q == ST_FIN);
    assign vl_out      = vl_q;
    assign exc_req     = (st_q == ST_FIN) && exc_q;
endmodule

// File: rtl/ff_loop_ctrl.sv
`timescale 1ns/1ps
module ff_loop_ctrl
    import ff_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int IW    = $clog2(MAXVL),
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ff_mode,
    input  logic              rc1_mode,
    input  logic [1:0]        test_sel,
    input  logic              test_expect,
    input  logic [VLW-1:0]    vl_in,
    input  logic [MAXVL-1:0]  pred_mask,
    output logic              issue_valid,
    output logic [IW-1:0]     issue_idx,
    input  logic              rsp_valid,
    input  logic [3:0]        rsp_cond,
    input  logic              rsp_exc,
    output logic              wr_result,
    output logic              wr_cond,
    output logic              busy,
    output logic              done,
    output logic [VLW-1:0]    vl_out,
    output logic              exc_req
);
    logic [VLW-1:0]   cur;
    ff_mode_e         cfg_mode;
    logic             cfg_rc1;
    cond_bit_e        cfg_sel;
    logic             cfg_exp;
    logic [VLW-1:0]   cfg_vl;
    logic [MAXVL-1:0] cfg_mask;
    logic             na_found;
    logic [IW-1:0]    na_idx;
    elem_verdict_t    verdict;
    logic             accept;

    ff_seq #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode_in    (ff_mode_e'(ff_mode)),
        .rc1_in     (rc1_mode),
        .sel_in     (cond_bit_e'(test_sel)),
        .exp_in     (test_expect),
        .vl_in      (vl_in),
        .mask_in    (pred_mask),
        .na_found   (na_found),
        .na_idx     (na_idx),
        .rsp_valid  (rsp_valid),
        .verdict    (verdict),
        .cur        (cur),
        .cfg_mode   (cfg_mode),
        .cfg_rc1    (cfg_rc1),
        .cfg_sel    (cfg_sel),
        .cfg_exp    (cfg_exp),
        .cfg_vl     (cfg_vl),
        .cfg_mask   (cfg_mask),
        .issue_valid(issue_valid),
        .busy       (busy),
        .done       (done),
        .vl_out     (vl_out),
        .exc_req    (exc_req)
    );

    ff_next_active #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_next (
        .from_idx(cur),
        .limit   (cfg_vl),
        .mask    (cfg_mask),
        .found   (na_found),
        .idx     (na_idx)
    );

    ff_elem_eval u_eval (
        .mode      (cfg_mode),
        .rc1       (cfg_rc1),
        .sel       (cfg_sel),
        .expect_val(cfg_exp),
        .first_elem(na_idx == '0),
        .cond_in   (rsp_cond),
        .exc_in    (rsp_exc),
        .verdict   (verdict)
    );

    assign issue_idx = na_idx;
    assign accept    = issue_valid && rsp_valid;
    assign wr_result = accept && verdict.wr_res;
    assign wr_cond   = accept && verdict.wr_cond;
endmodule

// File: rtl/ff_loop_chk.sv
`timescale 1ns/1ps
module ff_loop_chk #(
    parameter int MAXVL = 16,
    parameter int IW    = $clog2(MAXVL),
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             issue_valid,
    input logic [IW-1:0]    issue_idx,
    input logic             rsp_valid,
    input logic             wr_result,
    input logic             wr_cond,
    input logic             done,
    input logic             exc_req,
    input logic [VLW-1:0]   vl_out,
    input logic             cfg_mode,
    input logic             cfg_rc1,
    input logic [VLW-1:0]   cfg_vl,
    input logic [MAXVL-1:0] cfg_mask
);
    logic          seen_q;
    logic [IW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (issue_valid && rsp_valid) begin
            seen_q <= 1'b1;
            last_q <= issue_idx;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !issue_valid && !exc_req));

    assert_ascending_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && rsp_valid && seen_q) |-> (issue_idx > last_q));

    assert_masked_skip_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> cfg_mask[issue_idx]);

    assert_writes_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_result || wr_cond) |-> (issue_valid && rsp_valid));

    assert_raise_only_ldst_R5: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (done && !cfg_mode && vl_out == cfg_vl));

    assert_cond_never_grows_R7: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_mode) |-> (vl_out <= cfg_vl && !exc_req));

    assert_rc1_no_result_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && cfg_rc1) |-> !wr_result);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !rsp_valid) |=> (issue_valid && $stable(issue_idx)));
endmodule

bind ff_loop_ctrl ff_loop_chk #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .issue_valid(issue_valid),
    .issue_idx  (issue_idx),
    .rsp_valid  (rsp_valid),
    .wr_result  (wr_result),
    .wr_cond    (wr_cond),
    .done       (done),
    .exc_req    (exc_req),
    .vl_out     (vl_out),
    .cfg_mode   (cfg_mode),
    .cfg_rc1    (cfg_rc1),
    .cfg_vl     (cfg_vl),
    .cfg_mask   (cfg_mask)
);

// File: tb/sim_ff_loop_ctrl.sv
`timescale 1ns/1ps
module sim_ff_loop_ctrl;
    localparam int MAXVL = 16;
    localparam int IW    = $clog2(MAXVL);
    localparam int VLW   = $clog2(MAXVL + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             ff_mode = 1'b0;
    logic             rc1_mode = 1'b0;
    logic [1:0]       test_sel = 2'd0;
    logic             test_expect = 1'b0;
    logic [VLW-1:0]   vl_in = '0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic             issue_valid;
    logic [IW-1:0]    issue_idx;
    logic             rsp_valid;
    logic [3:0]       rsp_cond;
    logic             rsp_exc;
    logic             wr_result, wr_cond, busy, done, exc_req;
    logic [VLW-1:0]   vl_out;

    logic [3:0]       cr_tab  [MAXVL];
    logic             exc_tab [MAXVL];
    logic             stall = 1'b0;

    int errors = 0;
    int checks = 0;
    int res_log, cond_log, iss_log, last_iss;
    logic order_bad;

    always #2.5 clk = ~clk;

    ff_loop_ctrl #(.MAXVL(MAXVL)) u0 (
        .clk(clk), .rst(rst), .start(start), .ff_mode(ff_mode), .rc1_mode(rc1_mode),
        .test_sel(test_sel), .test_expect(test_expect), .vl_in(vl_in), .pred_mask(pred_mask),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .rsp_valid(rsp_valid),
        .rsp_cond(rsp_cond), .rsp_exc(rsp_exc), .wr_result(wr_result), .wr_cond(wr_cond),
        .busy(busy), .done(done), .vl_out(vl_out), .exc_req(exc_req)
    );

    // Datapath stand-in: answers from the tables for the presented index.
    assign rsp_valid = issue_valid && !stall;
    assign rsp_cond  = cr_tab[issue_idx];
    assign rsp_exc   = exc_tab[issue_idx];

    always @(negedge clk) begin
        if (issue_valid && rsp_valid) begin
            if (int'(issue_idx) <= last_iss) order_bad = 1'b1;
            last_iss = int'(issue_idx);
            iss_log  = iss_log | (1 << issue_idx);
        end
        if (wr_result) res_log  = res_log  | (1 << issue_idx);
        if (wr_cond)   cond_log = cond_log | (1 << issue_idx);
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_tables();
        for (int i = 0; i < MAXVL; i++) begin
            cr_tab[i]  = 4'b0000;
            exc_tab[i] = 1'b0;
        end
    endtask

    task automatic wait_done(input string req, output logic ok);
        ok = 1'b0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
        if (!ok) chk(1'b0, req, "timeout waiting for done", 0, 1);
    endtask

    // Runs one loop and compares it against a model built from the requirements.
    task automatic run_case(input logic m, input logic r1, input logic [1:0] bs,
                            input logic ev, input int vl, input int mask, input string req);
        int e_vl, e_res, e_cond, e_iss;
        logic e_exc, ok;
        int tb;
        e_vl = vl; e_res = 0; e_cond = 0; e_iss = 0; e_exc = 1'b0;
        tb = r1 ? 2 : int'(bs);
        for (int i = 0; i < vl; i++) begin
            if (((mask >> i) & 1) == 0) continue;
            e_iss |= (1 << i);
            if (!m) begin
                if (exc_tab[i]) begin
                    if (i == 0) e_exc = 1'b1; else e_vl = i;
                    break;
                end
                e_res |= (1 << i);
            end else begin
                if (cr_tab[i][tb] != ev) begin
                    e_vl = i;
                    break;
                end
                e_cond |= (1 << i);
                if (!r1) e_res |= (1 << i);
            end
        end
        @(negedge clk);
        res_log = 0; cond_log = 0; iss_log = 0; last_iss = -1; order_bad = 1'b0;
        ff_mode = m; rc1_mode = r1; test_sel = bs; test_expect = ev;
        vl_in = VLW'(vl); pred_mask = MAXVL'(mask); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(req, ok);
        if (ok) begin
            chk(int'(vl_out) == e_vl, req, "vl_out", int'(vl_out), e_vl);
            chk(exc_req == e_exc, req, "exc_req", int'(exc_req), int'(e_exc));
            chk(res_log == e_res, req, "result writes", res_log, e_res);
            chk(cond_log == e_cond, req, "cond writes", cond_log, e_cond);
            chk(iss_log == e_iss, req, "issued set", iss_log, e_iss);
            chk(!order_bad, "R2", "issue order", int'(order_bad), 0);
            @(negedge clk);
            chk(!done, "R10", "done width", int'(done), 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !issue_valid && !exc_req, "R1", "idle outputs",
            int'({busy, done, issue_valid, exc_req}), 0);
        chk(vl_out == '0, "R1", "vl_out", int'(vl_out), 0);
    endtask

    task automatic t_ldst_clean();
        clear_tables();
        run_case(1'b0, 1'b0, 2'd0, 1'b0, 8, 16'hFFFF, "R3");
    endtask

    task automatic t_ldst_trunc();
        clear_tables();
        exc_tab[5] = 1'b1;
        exc_tab[7] = 1'b1;
        run_case(1'b0, 1'b0, 2'd0, 1'b0, 10, 16'hFFFF, "R4");
    endtask

    task automatic t_ldst_raise();
        clear_tables();
        exc_tab[0] = 1'b1;
        run_case(1'b0, 1'b0, 2'd0, 1'b0, 8, 16'hFFFF, "R5");
    endtask

    task automatic t_cond_pass();
        clear_tables();
        for (int i = 0; i < MAXVL; i++) cr_tab[i] = 4'b0010;
        exc_tab[2] = 1'b1;  // fault flag must be ignored in condition mode
        run_case(1'b1, 1'b0, 2'd1, 1'b1, 12, 16'hFFFF, "R6");
    endtask

    task automatic t_cond_fail_mid();
        clear_tables();
        cr_tab[3] = 4'b1000;  // so bit set fails expect=0
        run_case(1'b1, 1'b0, 2'd3, 1'b0, 9, 16'hFFFF, "R7");
    endtask

    task automatic t_cond_fail_zero();
        clear_tables();
        for (int i = 1; i < MAXVL; i++) cr_tab[i] = 4'b0100;
        run_case(1'b1, 1'b0, 2'd2, 1'b1, 6, 16'hFFFF, "R7");
    endtask

    task automatic t_rc1();
        clear_tables();
        for (int i = 0; i < MAXVL; i++) cr_tab[i] = 4'b0101;  // eq and lt set
        cr_tab[4] = 4'b0001;                                  // lt set, eq clear
        run_case(1'b1, 1'b1, 2'd0, 1'b1, 8, 16'hFFFF, "R8");
    endtask

    task automatic t_masked();
        clear_tables();
        for (int i = 0; i < MAXVL; i++) cr_tab[i] = 4'b0100;
        cr_tab[2] = 4'b0000;  // would fail, but masked
        cr_tab[6] = 4'b0000;  // would fail, but beyond vl
        run_case(1'b1, 1'b0, 2'd2, 1'b1, 6, 16'h003B, "R9");
        clear_tables();
        exc_tab[1] = 1'b1;    // masked load/store fault
        run_case(1'b0, 1'b0, 2'd0, 1'b0, 5, 16'h001D, "R9");
    endtask

    task automatic t_empty();
        clear_tables();
        run_case(1'b0, 1'b0, 2'd0, 1'b0, 0, 16'hFFFF, "R12");
        chk(iss_log == 0, "R12", "issued with vl 0", iss_log, 0);
        run_case(1'b1, 1'b0, 2'd2, 1'b1, 7, 16'h0000, "R12");
    endtask

    task automatic t_stall_and_restart();
        logic ok;
        clear_tables();
        @(negedge clk);
        res_log = 0; cond_log = 0; iss_log = 0; last_iss = -1; order_bad = 1'b0;
        stall = 1'b1;
        ff_mode = 1'b0; rc1_mode = 1'b0; vl_in = VLW'(4); pred_mask = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(issue_valid && issue_idx == '0, "R11", "held index",
                int'(issue_idx), 0);
            chk(!wr_result && !wr_cond, "R11", "write while stalled",
                int'({wr_result, wr_cond}), 0);
        end
        // second start while busy with a different configuration
        ff_mode = 1'b1; vl_in = VLW'(2); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stall = 1'b0;
        wait_done("R13", ok);
        if (ok) begin
            chk(int'(vl_out) == 4, "R13", "vl_out after ignored start", int'(vl_out), 4);
            chk(res_log == 'hF, "R13", "result writes", res_log, 'hF);
        end
    endtask

    initial begin
        clear_tables();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_ldst_clean();
        t_ldst_trunc();
        t_ldst_raise();
        t_cond_pass();
        t_cond_fail_mid();
        t_cond_fail_zero();
        t_rc1();
        t_masked();
        t_empty();
        t_stall_and_restart();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule